// File: doc/BRIEF.md
# Ping-Pong Bank Swap Coordinator

This block decides which of two database memory banks the matching core reads and which one the prefetch engine writes. The two banks are used as a double buffer. While the core works through the part held in one bank, the prefetch engine loads the next part into the other bank. Each side reports completion with a one-cycle pulse. The block latches each pulse in a sticky flag. Once both flags are up, it raises an interrupt to the core.

The core's interrupt handler prepares the next iteration and then acknowledges. On an accepted acknowledge, the block swaps the two bank roles and clears both flags, which drops the interrupt. An acknowledge that arrives while no interrupt is pending is ignored. A completion pulse that lands in the same cycle as an accepted acknowledge is kept and counts toward the next iteration.

Top module: `dbswap_ctrl`

## Requirements
- R1: After reset, `proc_bank` is 0, `fill_bank` is 1 and `swap_irq` is 0. Both completion flags start clear.
- R2: A single `fetch_done` pulse or a single `proc_done` pulse is held in its own flag. On its own, a flag does not raise `swap_irq`.
- R3: `swap_irq` is 1 in the cycle after the later of the two flags has been captured, and only when both flags are set.
- R4: A `fetch_done` and a `proc_done` pulse in the same cycle are both captured. `swap_irq` then reads 1 on the next cycle.
- R5: Once raised, `swap_irq` stays at 1 until an acknowledge is accepted.
- R6: An acknowledge is accepted when `swap_ack` is 1 while `swap_irq` is 1. After the edge, `proc_bank` and `fill_bank` each hold the inverse of their previous value, and both flags are clear.
- R7: A `swap_ack` while `swap_irq` is 0 has no effect on the bank roles or on the flags.
- R8: `proc_bank` and `fill_bank` never name the same bank.
- R9: A completion pulse in the same cycle as an accepted acknowledge sets its flag for the new iteration. All other flag state clears.
- R10: Repeated pulses on a flag that is already set have no further effect. One accepted acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_done | input | 1 | One-cycle pulse from the prefetch engine: the fill bank is loaded |
| proc_done | input | 1 | One-cycle pulse from the core: the processing bank is finished |
| swap_ack | input | 1 | Acknowledge from the core's interrupt handler |
| swap_irq | output | 1 | Interrupt: both sides are done and the banks may swap |
| proc_bank | output | 1 | Bank index currently assigned to the core |
| fill_bank | output | 1 | Bank index currently assigned to the prefetch engine |

## Verification
The join is driven in several ways. Each done pulse is sent on its own, the two arrive in both orders, they arrive in the same cycle, and pulses repeat while a flag is already set. These cases separate a true AND of sticky flags from an OR, from a single-pulse match, and from a flag that re-arms on every pulse. Acknowledges are sent while the interrupt is pending, while it is idle, and together with a new done pulse. These cases tell an accepted swap from an ignored one, and show whether a coincident pulse survives the clear. A long pseudo-random sweep over all eight input combinations compares every cycle against an arithmetic model of the flags and the bank index.

// File: rtl/dbswap_pkg.sv
package dbswap_pkg;

  localparam int unsigned NUM_PARTIES = 2;
  localparam int unsigned FETCH_IDX   = 0;
  localparam int unsigned PROC_IDX    = 1;

  typedef logic [NUM_PARTIES-1:0] party_vec_t;

  // Sticky flag update: a clear takes this cycle's set into the new round
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    logic nxt;
    if (clr) nxt = set;
    else     nxt = cur | set;
    return nxt;
  endfunction

  // Join of all completion flags
  function automatic logic all_joined(input party_vec_t f);
    return &f;
  endfunction

  // Bank index after an optional swap
  function automatic logic role_next(input logic cur, input logic swap);
    return swap ? ~cur : cur;
  endfunction

endpackage

// File: rtl/dbswap_flag.sv
module dbswap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  import dbswap_pkg::*;

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, set_i, clr_i);
  end

  assign flag_o = flag_q;

  // A set flag stays set until a clear arrives (R10)
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // A pulse always leaves the flag set (R2, R9)
  assert_flag_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

endmodule

// File: rtl/dbswap_roles.sv
module dbswap_roles (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_i,
  output logic proc_o,
  output logic fill_o
);
  import dbswap_pkg::*;

  logic proc_q;
  logic fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proc_q <= 1'b0;
      fill_q <= 1'b1;
    end else begin
      proc_q <= role_next(proc_q, swap_i);
      fill_q <= role_next(fill_q, swap_i);
    end
  end

  assign proc_o = proc_q;
  assign fill_o = fill_q;

  assert_banks_differ_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proc_q != fill_q);

  assert_roles_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> ($stable(proc_q) && $stable(fill_q)));

endmodule

// File: rtl/dbswap_ctrl.sv
module dbswap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_done,
  input  logic proc_done,
  input  logic swap_ack,
  output logic swap_irq,
  output logic proc_bank,
  output logic fill_bank
);
  import dbswap_pkg::*;

  party_vec_t done_pulse;
  party_vec_t flags;
  logic       joined;
  logic       ack_taken;

  assign done_pulse[FETCH_IDX] = fetch_done;
  assign done_pulse[PROC_IDX]  = proc_done;

  generate
    for (genvar g = 0; g < NUM_PARTIES; g++) begin : g_flag
      dbswap_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (done_pulse[g]),
        .clr_i  (ack_taken),
        .flag_o (flags[g])
      );
    end
  endgenerate

  assign joined    = all_joined(flags);
  assign ack_taken = swap_ack & joined;
  assign swap_irq  = joined;

  dbswap_roles u_roles (
    .clk    (clk),
    .rst_n  (rst_n),
    .swap_i (ack_taken),
    .proc_o (proc_bank),
    .fill_o (fill_bank)
  );

  // Both pulses together raise the interrupt on the next cycle (R4)
  assert_join_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && proc_done) |=> swap_irq);

  // The interrupt persists until it is acknowledged (R5)
  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_irq && !swap_ack) |=> swap_irq);

  // An accepted acknowledge swaps the roles (R6)
  assert_swap_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_irq && swap_ack) |=> (proc_bank != $past(proc_bank)));

  // An accepted acknowledge with no new pulses drops the interrupt (R6)
  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_irq && swap_ack && !fetch_done && !proc_done) |=> !swap_irq);

  // An idle acknowledge is ignored (R7)
  assert_idle_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_irq && swap_ack) |=> $stable(proc_bank));

  // A rising interrupt needs at least one pulse in the previous cycle (R3)
  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_irq && !fetch_done && !proc_done) |=> !swap_irq);

endmodule

// File: tb/tb_dbswap_ctrl.sv
module tb_dbswap_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_done = 1'b0;
  logic proc_done = 1'b0;
  logic swap_ack = 1'b0;
  logic swap_irq;
  logic proc_bank;
  logic fill_bank;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  bit m_ff = 0, m_pf = 0, m_bank = 0;

  always #2 clk = ~clk;

  dbswap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .proc_done(proc_done),
    .swap_ack(swap_ack), .swap_irq(swap_irq), .proc_bank(proc_bank), .fill_bank(fill_bank)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs, advance the model, compare after the edge
  task automatic step(input bit f, input bit p, input bit a, input string tag);
    bit irq_before;
    @(negedge clk);
    fetch_done = f; proc_done = p; swap_ack = a;
    irq_before = m_ff & m_pf;
    @(posedge clk);
    #1;
    if (a && irq_before) begin
      m_ff = f; m_pf = p; m_bank = ~m_bank;
    end else begin
      m_ff = m_ff | f; m_pf = m_pf | p;
    end
    check(tag, swap_irq, m_ff & m_pf, "swap_irq");
    check(tag, proc_bank, m_bank, "proc_bank");
    check(tag, fill_bank, ~m_bank, "fill_bank");
    check("R8", proc_bank != fill_bank, 1'b1, "banks distinct");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    #9;
    check("R1", swap_irq, 1'b0, "irq in reset");
    check("R1", proc_bank, 1'b0, "proc_bank in reset");
    check("R1", fill_bank, 1'b1, "fill_bank in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, "R1");

    // Single fetch done: held, no irq
    step(1, 0, 0, "R2");
    step(0, 0, 0, "R2");
    step(0, 0, 0, "R2");
    // Core done later: join
    step(0, 1, 0, "R3");
    step(0, 0, 0, "R5");
    step(0, 0, 0, "R5");
    step(0, 0, 1, "R6");
    step(0, 0, 0, "R6");

    // Reverse order
    step(0, 1, 0, "R2");
    step(0, 0, 0, "R2");
    step(1, 0, 0, "R3");
    step(0, 0, 1, "R6");

    // Idle acknowledges ignored, including with one flag set
    step(0, 0, 1, "R7");
    step(1, 0, 0, "R7");
    step(0, 0, 1, "R7");
    step(0, 0, 1, "R7");
    step(0, 1, 0, "R7");
    step(0, 0, 1, "R6");

    // Simultaneous pulses
    step(1, 1, 0, "R4");
    step(0, 0, 0, "R4");
    step(0, 0, 1, "R6");

    // Repeated pulses, then one acknowledge clears everything
    step(1, 0, 0, "R10");
    step(1, 0, 0, "R10");
    step(1, 0, 0, "R10");
    step(0, 1, 0, "R10");
    step(0, 1, 0, "R10");
    step(0, 0, 1, "R10");
    step(0, 0, 0, "R10");
    step(0, 1, 0, "R10");

    // Pulse coincident with an accepted acknowledge carries over
    step(1, 0, 0, "R9");
    step(1, 0, 1, "R9");
    step(0, 0, 0, "R9");
    step(0, 1, 0, "R9");
    step(1, 1, 1, "R9");
    step(0, 0, 0, "R9");
    step(0, 0, 1, "R9");

    // Pseudo-random sweep over all input combinations
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3], lfsr[6] | lfsr[9], "R3");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule